// File: doc/BRIEF.md
# Paged Memory Bank Mapper

The mapper places a 16-bit CPU address space over a 64-block physical space. The CPU space is cut into eight windows of 8 KB, and each window holds a 6-bit block number. Software programs the windows through two I/O ports. One port sets a window index. The other port reads or writes the block number of the indexed window. After each data-port access the index moves to the next window, so one index write followed by a run of data writes loads all eight windows in turn.

On every memory cycle the mapper uses the top three CPU address bits to choose a window. It sends out that window's block number and the low 13 address bits as the offset. It also decodes the block number into a region class and returns the number of extra wait states that the region needs. For RAM and ROM regions the wait count depends on whether the cycle is an opcode fetch. The mapper raises an error flag when an opcode fetch lands in any video-memory class region.

Top module: `bank_mapper`

## Requirements
- R1: After reset, window n holds block n for n = 0..7, and the index is 0.
- R2: A write to the index port (io_port=0) loads io_wdata[2:0] into the index. A read of the index port returns {5'b0, index}. A read of the data port (io_port=1) returns {2'b00, block of the indexed window}.
- R3: After every data-port read or write the index advances by one, and it wraps from 7 to 0. An index-port access does not advance it.
- R4: A data-port write stores io_wdata[5:0] in the indexed window. The other windows do not change.
- R5: phys_block equals the block in window cpu_addr[15:13], and phys_offset equals cpu_addr[12:0].
- R6: The region code follows from phys_block: 00h-0Fh main RAM=1, 10h-1Fh extended RAM=2, 20h-27h standard graphic VRAM=3, 28h-2Fh extended graphic VRAM=4, 30h-31h standard read-modify-write VRAM=5, 32h-33h extended read-modify-write VRAM=6, 34h-37h boot ROM=7, 38h text VRAM=8, 39h character ROM=9, 3Ch-3Fh comms ROM=10, 3Ah-3Bh none=0.
- R7: With mem_req high, regions 3, 4 and 8 give wait_cnt=1, and regions 5, 6 and 9 give wait_cnt=2, whatever the value of m1.
- R8: With mem_req high, regions 1, 2, 7 and 10 give wait_cnt=1 when m1=1 and 0 when m1=0. Region 0 always gives 0.
- R9: fetch_err is 1 exactly when mem_req=1, m1=1 and the region is one of 3, 4, 5, 6, 8 or 9.
- R10: With mem_req low, wait_cnt and fetch_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_port | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| cpu_addr | input | 16 | CPU memory address |
| mem_req | input | 1 | Memory cycle in progress |
| m1 | input | 1 | Current cycle is an opcode fetch |
| phys_block | output | 6 | Translated block number |
| phys_offset | output | 13 | Offset within the block |
| region | output | 4 | Region class code |
| wait_cnt | output | 2 | Extra wait states for this cycle |
| fetch_err | output | 1 | Opcode fetch from a VRAM-class region |

## Verification
The assertions check three things on every cycle. The index steps by exactly one, modulo eight, after each data-port access and holds otherwise. The window file changes only on a data-port write. The wait count and the error flag stay consistent with the region code and with mem_req and m1. The scenarios in the bench are needed for the rest: the reset contents of the windows, the exact mapping from block number to region across all 64 values, address translation through reprogrammed windows, and the wrap of the index during long read and write runs. In those scenarios a reference model in the bench is compared against every output on every clock.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [3:0] {
    RG_NONE     = 4'd0,
    RG_MAIN     = 4'd1,
    RG_XRAM     = 4'd2,
    RG_GV_STD   = 4'd3,
    RG_GV_EXT   = 4'd4,
    RG_RMW_STD  = 4'd5,
    RG_RMW_EXT  = 4'd6,
    RG_BOOT     = 4'd7,
    RG_TEXT     = 4'd8,
    RG_CHAR     = 4'd9,
    RG_COMM     = 4'd10
  } region_e;

  function automatic region_e region_of(input logic [5:0] blk);
    if (blk < 6'h10)       return RG_MAIN;
    else if (blk < 6'h20)  return RG_XRAM;
    else if (blk < 6'h28)  return RG_GV_STD;
    else if (blk < 6'h30)  return RG_GV_EXT;
    else if (blk < 6'h32)  return RG_RMW_STD;
    else if (blk < 6'h34)  return RG_RMW_EXT;
    else if (blk < 6'h38)  return RG_BOOT;
    else if (blk == 6'h38) return RG_TEXT;
    else if (blk == 6'h39) return RG_CHAR;
    else if (blk < 6'h3C)  return RG_NONE;
    else                   return RG_COMM;
  endfunction

  function automatic logic is_vram(input region_e r);
    return (r == RG_GV_STD) || (r == RG_GV_EXT) || (r == RG_RMW_STD) ||
           (r == RG_RMW_EXT) || (r == RG_TEXT) || (r == RG_CHAR);
  endfunction

  function automatic logic [1:0] waits_of(input region_e r, input logic fetch);
    case (r)
      RG_GV_STD, RG_GV_EXT, RG_TEXT:   return 2'd1;
      RG_RMW_STD, RG_RMW_EXT, RG_CHAR: return 2'd2;
      RG_MAIN, RG_XRAM, RG_BOOT, RG_COMM: return fetch ? 2'd1 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/map_index_ctrl.sv
module map_index_ctrl #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             idx_step,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)        idx <= '0;
    else if (idx_load) idx <= load_val;
    else if (idx_step) idx <= idx + 1'b1;
  end

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_step && !idx_load) |=> (idx == $past(idx) + 1'b1));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_step && !idx_load) |=> $stable(idx));
endmodule

// File: rtl/map_window_regs.sv
module map_window_regs #(
  parameter int WIN_N = 8,
  parameter int BLK_W = 6,
  localparam int IDX_W = $clog2(WIN_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic [BLK_W-1:0] sel_blk,
  output logic [BLK_W-1:0] cpu_blk
);
  logic [WIN_N-1:0][BLK_W-1:0] win;

  for (genvar n = 0; n < WIN_N; n++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n)
        win[n] <= BLK_W'(n);
      else if (wr_en && wr_idx == IDX_W'(n))
        win[n] <= wr_blk;
    end
  end

  assign sel_blk = win[wr_idx];
  assign cpu_blk = win[cpu_idx];

  // R4
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(win));

  // R4
  win_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (win[$past(wr_idx)] == $past(wr_blk)));
endmodule

// File: rtl/map_region_decode.sv
module map_region_decode
  import mapper_pkg::*;
#(
  parameter int BLK_W = 6
) (
  input  logic             rst_n,
  input  logic [BLK_W-1:0] blk,
  input  logic             mem_req,
  input  logic             m1,
  output region_e          region,
  output logic [1:0]       wait_cnt,
  output logic             fetch_err
);
  logic vram_hit;

  always_comb begin
    region    = region_of(blk[5:0]);
    vram_hit  = is_vram(region);
    wait_cnt  = mem_req ? waits_of(region, m1) : 2'd0;
    fetch_err = mem_req && m1 && vram_hit;
  end

  always_comb begin
    if (rst_n) begin
      // R9
      fetch_vram_chk: assert (!fetch_err || (wait_cnt != 2'd0));
      // R10
      idle_quiet_chk: assert (mem_req || (wait_cnt == 2'd0 && !fetch_err));
      // R8
      none_zero_chk: assert (region != RG_NONE || wait_cnt == 2'd0);
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int ADDR_W = 16,
  parameter int WIN_N  = 8,
  parameter int BLK_W  = 6,
  localparam int IDX_W = $clog2(WIN_N),
  localparam int OFF_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              io_port,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_req,
  input  logic              m1,
  output logic [BLK_W-1:0]  phys_block,
  output logic [OFF_W-1:0]  phys_offset,
  output logic [3:0]        region,
  output logic [1:0]        wait_cnt,
  output logic              fetch_err
);
  import mapper_pkg::*;

  logic             idx_load, data_acc, data_wr;
  logic [IDX_W-1:0] idx;
  logic [BLK_W-1:0] sel_blk;
  region_e          region_q;

  assign idx_load = io_wr && !io_port;
  assign data_acc = (io_wr || io_rd) && io_port;
  assign data_wr  = io_wr && io_port;

  map_index_ctrl #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .idx_load(idx_load),
    .load_val(io_wdata[IDX_W-1:0]), .idx_step(data_acc), .idx(idx)
  );

  map_window_regs #(.WIN_N(WIN_N), .BLK_W(BLK_W)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_idx(idx),
    .wr_blk(io_wdata[BLK_W-1:0]), .cpu_idx(cpu_addr[ADDR_W-1 -: IDX_W]),
    .sel_blk(sel_blk), .cpu_blk(phys_block)
  );

  map_region_decode #(.BLK_W(BLK_W)) u_dec (
    .rst_n(rst_n), .blk(phys_block), .mem_req(mem_req), .m1(m1),
    .region(region_q), .wait_cnt(wait_cnt), .fetch_err(fetch_err)
  );

  assign region      = region_q;
  assign phys_offset = cpu_addr[OFF_W-1:0];
  assign io_rdata    = io_port ? 8'(sel_blk) : 8'(idx);

  // R9
  fetch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> (mem_req && m1));
endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_wr = 0, io_rd = 0, io_port = 0, mem_req = 0, m1 = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic [15:0] cpu_addr = 0;
  logic [5:0] phys_block;
  logic [12:0] phys_offset;
  logic [3:0] region;
  logic [1:0] wait_cnt;
  logic fetch_err;

  int tests = 0, fails = 0;
  int win[8];
  int idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_addr(cpu_addr),
    .mem_req(mem_req), .m1(m1), .phys_block(phys_block),
    .phys_offset(phys_offset), .region(region), .wait_cnt(wait_cnt),
    .fetch_err(fetch_err)
  );

  function automatic int exp_region(int b);
    if (b <= 15) return 1;
    if (b <= 31) return 2;
    if (b <= 39) return 3;
    if (b <= 47) return 4;
    if (b == 48 || b == 49) return 5;
    if (b == 50 || b == 51) return 6;
    if (b >= 52 && b <= 55) return 7;
    if (b == 56) return 8;
    if (b == 57) return 9;
    if (b >= 60) return 10;
    return 0;
  endfunction

  function automatic int exp_wait(int r, bit req, bit f);
    if (!req) return 0;
    if (r == 3 || r == 4 || r == 8) return 1;
    if (r == 5 || r == 6 || r == 9) return 2;
    if (r == 0) return 0;
    return f ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare at +1, update model at posedge
  task automatic step(bit wr, bit rd, bit port, int wd, int addr, bit req, bit f);
    int b, r;
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_port = port; io_wdata = 8'(wd);
    cpu_addr = 16'(addr); mem_req = req; m1 = f;
    #1;
    b = win[addr / 8192];
    r = exp_region(b);
    chk(port ? "R2 data rdata" : "R2/R3 index rdata", io_rdata, port ? win[idx] : idx);
    chk("R5 phys_block", phys_block, b);
    chk("R5 phys_offset", phys_offset, addr % 8192);
    chk("R6 region", region, r);
    chk(req ? "R7/R8 wait_cnt" : "R10 wait_cnt", wait_cnt, exp_wait(r, req, f));
    chk(req ? "R9 fetch_err" : "R10 fetch_err", fetch_err,
        (req && f && (r == 3 || r == 4 || r == 5 || r == 6 || r == 8 || r == 9)) ? 1 : 0);
    @(posedge clk);
    if (wr && !port) idx = wd % 8;
    else if ((wr || rd) && port) begin
      if (wr) win[idx] = wd % 64;
      idx = (idx + 1) % 8;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 8; n++) win[n] = n;
    idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset contents and index, via reads and translation
    step(0, 1, 0, 0, 0, 0, 0);
    chk("R1 index after reset", idx, 0);
    for (int n = 0; n < 8; n++) step(0, 0, 0, 0, n * 8192 + 100, 1, 0);
    // R3: nine data reads wrap the index
    for (int n = 0; n < 9; n++) step(0, 1, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    // R2/R4: load all windows through one index write
    step(1, 0, 0, 8'hF8 + 3, 0, 0, 0);
    for (int n = 0; n < 8; n++) step(1, 0, 1, 8'hC0 | ((n * 9 + 20) % 64), 0, 0, 0);
    for (int n = 0; n < 8; n++) step(0, 0, 0, 0, n * 8192 + n * 77, 1, n % 2);
    // R6/R7/R8/R9/R10: sweep every block through window 5
    for (int b = 0; b < 64; b++) begin
      step(1, 0, 0, 5, 0, 0, 0);
      step(1, 0, 1, b, 0, 0, 0);
      step(0, 0, 0, 0, 5 * 8192 + b * 13, 1, 0);
      step(0, 0, 0, 0, 5 * 8192 + 8191, 1, 1);
      step(0, 0, 0, 0, 5 * 8192, 0, 1);
    end
    // R4: other windows unchanged, readback of all
    step(1, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 8; n++) step(0, 1, 1, 0, 65535, 1, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule